// File: doc/BRIEF.md
# Power-Fail Write-Protect Controller

This block sits between a host that drives active-low memory controls (chip select, write strobe, read strobe) and a 128K x 8 memory array. It decodes each cycle's controls into one of four access modes, passes reads and writes to the array, and drives the host data bus only on a read. An external comparator supplies a digital power-fail flag, which the controller samples on every clock edge.

When power fails, new accesses are refused at once. An access that is already under way is allowed to run to its end, but only for a bounded number of cycles. After that the array is fully isolated: no strobes reach it, its address and write data are held at zero, and the host bus is left undriven. Once the flag clears, isolation continues for a programmable recovery window before normal service resumes. A power failure during that window sends the controller back to full isolation and restarts the window.

All times are counted in clock cycles. The drain limit is `DRAIN_CYCLES` and the recovery window is `RECOVER_CYCLES`.

Top module: `pfwp_ctrl`

## Requirements
- R1: While `hostCeN` is high, no array strobe is issued and `hostDataOe` is 0, whatever `hostWeN` and `hostOeN` are.
- R2: With `hostCeN` low, `hostWeN` high and `hostOeN` high (output-disable mode), no array strobe is issued and `hostDataOe` is 0.
- R3: With `hostCeN` low, `hostWeN` high and `hostOeN` low in normal service, `memRe` is 1, `memAddr` equals `hostAddr`, `hostDataOe` is 1 and `hostDataOut` equals `memRdData` in the same cycle.
- R4: With `hostCeN` low and `hostWeN` low in normal service, `memWe` is 1, `memAddr`/`memWrData` carry `hostAddr`/`hostDataIn`, and `hostDataOe` is 0 for either level of `hostOeN`.
- R5: If a clock edge samples `pwrFail` high while normal and `hostCeN` high, every later cycle blocks access until recovery completes, and `protectedOut` is 1 from the cycle after that edge.
- R6: If that edge samples `hostCeN` low, the access type active at that edge keeps running. It ends when `hostCeN` returns high, or when `hostWeN` returns high for a write. The controller then moves to full isolation.
- R7: An access that has not ended within `DRAIN_CYCLES` cycles after detection is cut off: isolation begins in the next cycle.
- R8: Under isolation and during recovery, `memWe`, `memRe` and `hostDataOe` are 0, `memAddr` and `memWrData` are 0, and `hostDataOut` is 0.
- R9: While an access is being drained, a different access type started by the host (e.g. a write during a draining read) is not passed to the array.
- R10: After `pwrFail` is sampled low under isolation, access stays blocked for exactly `RECOVER_CYCLES` further cycles, and then normal service resumes with `protectedOut` at 0.
- R11: `pwrFail` sampled high during recovery returns the controller to isolation and restarts the full recovery window.
- R12: Reset (`rstN` low) puts the controller into normal service with `protectedOut` at 0. `protectedOut` is 1 in every draining, isolated or recovering cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrFail | input | 1 | Power-fail flag from the external comparator, active high |
| hostCeN | input | 1 | Host chip select, active low |
| hostWeN | input | 1 | Host write strobe, active low |
| hostOeN | input | 1 | Host read/output strobe, active low |
| hostAddr | input | 17 | Host word address |
| hostDataIn | input | 8 | Host write data |
| hostDataOut | output | 8 | Read data toward the host, 0 when not driven |
| hostDataOe | output | 1 | Host bus drive enable (0 = high impedance) |
| memAddr | output | 17 | Array address, 0 when no access passes |
| memWrData | output | 8 | Array write data, 0 when no write passes |
| memWe | output | 1 | Array write strobe |
| memRe | output | 1 | Array read strobe |
| memRdData | input | 8 | Array read data |
| protectedOut | output | 1 | High whenever the controller is not in normal service |

## Verification
The hard cases are cycles where the power-fail flag arrives while the host has an access open, so that draining and blocking apply to the same chip-select period. The bench raises the flag during a write and during a read, then changes the host controls in the draining cycles: the write strobe is released, or a write is started inside a draining read. It also holds the read past the drain limit. In each cycle it predicts from the requirements whether that access may still reach the array. A second overlap is a new power failure during the recovery window. That case is judged by counting the blocked cycles until service resumes.

// File: rtl/pfwp_pkg.sv
package pfwp_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_OUTDIS = 2'd1,
    MODE_READ   = 2'd2,
    MODE_WRITE  = 2'd3
  } accessMode_t;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_PROT   = 2'd2,
    ST_RECOV  = 2'd3
  } guardState_t;

  typedef struct packed {
    logic passRead;
    logic passWrite;
  } strobe_t;

  function automatic accessMode_t decodeMode(input logic ceN, input logic weN, input logic oeN);
    if (ceN)       return MODE_IDLE;
    else if (!weN) return MODE_WRITE;
    else if (!oeN) return MODE_READ;
    else           return MODE_OUTDIS;
  endfunction

endpackage

// File: rtl/pfwp_control.sv
module pfwp_control
  import pfwp_pkg::*;
#(
  parameter int DRAIN_CYCLES   = 16,
  parameter int RECOVER_CYCLES = 12_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrFail,
  input  logic        ceN,
  input  logic        weN,
  input  logic        oeN,
  output strobe_t     strobes,
  output guardState_t stateNow
);

  localparam int LIMIT_MAX = (DRAIN_CYCLES > RECOVER_CYCLES) ? DRAIN_CYCLES : RECOVER_CYCLES;
  localparam int CNT_W     = $clog2(LIMIT_MAX + 1);
  localparam logic [CNT_W-1:0] DRAIN_LAST = CNT_W'(DRAIN_CYCLES - 1);
  localparam logic [CNT_W-1:0] RECOV_LAST = CNT_W'(RECOVER_CYCLES - 1);

  guardState_t      state, stateNext;
  accessMode_t      mode, drainMode, drainModeNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             drainEnd;
  logic             allowAccess;

  always_comb mode = decodeMode(ceN, weN, oeN);

  // the held access is over once select drops, or the write strobe is released
  always_comb drainEnd = ceN | ((drainMode == MODE_WRITE) & weN);

  always_comb begin
    stateNext     = state;
    cntNext       = cnt;
    drainModeNext = drainMode;
    unique case (state)
      ST_NORMAL: begin
        if (pwrFail) begin
          cntNext = '0;
          if (!ceN) begin
            stateNext     = ST_DRAIN;
            drainModeNext = mode;
          end else begin
            stateNext = ST_PROT;
          end
        end
      end
      ST_DRAIN: begin
        if (drainEnd || cnt == DRAIN_LAST) begin
          stateNext = ST_PROT;
          cntNext   = '0;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_PROT: begin
        cntNext = '0;
        if (!pwrFail) stateNext = ST_RECOV;
      end
      ST_RECOV: begin
        if (pwrFail) begin
          stateNext = ST_PROT;
          cntNext   = '0;
        end else if (cnt == RECOV_LAST) begin
          stateNext = ST_NORMAL;
          cntNext   = '0;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      default: stateNext = ST_PROT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_NORMAL;
      cnt       <= '0;
      drainMode <= MODE_IDLE;
    end else begin
      state     <= stateNext;
      cnt       <= cntNext;
      drainMode <= drainModeNext;
    end
  end

  always_comb allowAccess = (state == ST_NORMAL) | ((state == ST_DRAIN) & (mode == drainMode));

  always_comb begin
    strobes.passRead  = allowAccess & (mode == MODE_READ);
    strobes.passWrite = allowAccess & (mode == MODE_WRITE);
  end

  assign stateNow = state;

endmodule

// File: rtl/pfwp_datapath.sv
module pfwp_datapath
  import pfwp_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWe,
  output logic              memRe,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe
);

  logic anyPass;

  always_comb begin
    anyPass     = strobes.passRead | strobes.passWrite;
    memAddr     = anyPass ? hostAddr : '0;
    memWrData   = strobes.passWrite ? hostDataIn : '0;
    memWe       = strobes.passWrite;
    memRe       = strobes.passRead;
    hostDataOut = strobes.passRead ? memRdData : '0;
    hostDataOe  = strobes.passRead;
  end

endmodule

// File: rtl/pfwp_ctrl.sv
module pfwp_ctrl
  import pfwp_pkg::*;
#(
  parameter int ADDR_W         = 17,
  parameter int DATA_W         = 8,
  parameter int DRAIN_CYCLES   = 16,
  parameter int RECOVER_CYCLES = 12_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrFail,
  input  logic              hostCeN,
  input  logic              hostWeN,
  input  logic              hostOeN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWe,
  output logic              memRe,
  input  logic [DATA_W-1:0] memRdData,
  output logic              protectedOut
);

  strobe_t     strobes;
  guardState_t stateNow;

  pfwp_control #(
    .DRAIN_CYCLES  (DRAIN_CYCLES),
    .RECOVER_CYCLES(RECOVER_CYCLES)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .pwrFail (pwrFail),
    .ceN     (hostCeN),
    .weN     (hostWeN),
    .oeN     (hostOeN),
    .strobes (strobes),
    .stateNow(stateNow)
  );

  pfwp_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uPath (
    .strobes    (strobes),
    .hostAddr   (hostAddr),
    .hostDataIn (hostDataIn),
    .memRdData  (memRdData),
    .memAddr    (memAddr),
    .memWrData  (memWrData),
    .memWe      (memWe),
    .memRe      (memRe),
    .hostDataOut(hostDataOut),
    .hostDataOe (hostDataOe)
  );

  assign protectedOut = (stateNow != ST_NORMAL);

endmodule

// File: rtl/pfwp_chk.sv
module pfwp_chk
  import pfwp_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int DRAIN_CYCLES = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              pwrFail,
  input logic              hostCeN,
  input logic              hostWeN,
  input logic              hostDataOe,
  input logic [DATA_W-1:0] hostDataOut,
  input logic [DATA_W-1:0] memRdData,
  input logic              memWe,
  input logic              memRe,
  input logic              protectedOut,
  input guardState_t       stateNow
);

  logic [31:0] drainRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) drainRun <= '0;
    else if (stateNow == ST_DRAIN) drainRun <= drainRun + 1;
    else drainRun <= '0;
  end

  // R1
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostCeN |-> (!memWe && !memRe && !hostDataOe));

  // R3
  read_data_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostDataOe |-> (memRe && hostDataOut == memRdData));

  // R4
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hostCeN && !hostWeN) |-> !hostDataOe);

  // R5
  idle_fail_protect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateNow == ST_NORMAL && pwrFail && hostCeN) |=> (stateNow == ST_PROT));

  // R7
  drain_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (drainRun <= DRAIN_CYCLES));

  // R8
  isolated_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateNow == ST_PROT || stateNow == ST_RECOV) |-> (!memWe && !memRe && !hostDataOe));

  // R10
  resume_after_recov_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(protectedOut) |-> ($past(stateNow) == ST_RECOV && !$past(pwrFail)));

  // R11
  recov_refail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateNow == ST_RECOV && pwrFail) |=> (stateNow == ST_PROT));

  // R12
  status_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || memRe) |-> (stateNow == ST_NORMAL || stateNow == ST_DRAIN));

endmodule

bind pfwp_ctrl pfwp_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .DRAIN_CYCLES(DRAIN_CYCLES)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .pwrFail     (pwrFail),
  .hostCeN     (hostCeN),
  .hostWeN     (hostWeN),
  .hostDataOe  (hostDataOe),
  .hostDataOut (hostDataOut),
  .memRdData   (memRdData),
  .memWe       (memWe),
  .memRe       (memRe),
  .protectedOut(protectedOut),
  .stateNow    (stateNow)
);

// File: tb/sim_pfwp_ctrl.sv
module sim_pfwp_ctrl;

  localparam int WPT = 4;
  localparam int CER = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pwrFail = 1'b0;
  logic        hostCeN = 1'b1, hostWeN = 1'b1, hostOeN = 1'b1;
  logic [16:0] hostAddr = '0;
  logic [7:0]  hostDataIn = '0;
  logic [7:0]  hostDataOut;
  logic        hostDataOe;
  logic [16:0] memAddr;
  logic [7:0]  memWrData;
  logic        memWe, memRe;
  logic [7:0]  memRdData;
  logic        protectedOut;

  typedef struct packed {
    logic        we;
    logic        re;
    logic        oe;
    logic        prot;
    logic [7:0]  dout;
    logic [7:0]  wdata;
    logic [16:0] addr;
  } obs_t;

  obs_t  expQ[$];
  string tagQ[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;

  always #5 clk = ~clk;

  // array model: read data derived from the address
  assign memRdData = memAddr[7:0] ^ 8'h5A;

  pfwp_ctrl #(.DRAIN_CYCLES(WPT), .RECOVER_CYCLES(CER)) u0 (
    .clk(clk), .rstN(rstN), .pwrFail(pwrFail),
    .hostCeN(hostCeN), .hostWeN(hostWeN), .hostOeN(hostOeN),
    .hostAddr(hostAddr), .hostDataIn(hostDataIn),
    .hostDataOut(hostDataOut), .hostDataOe(hostDataOe),
    .memAddr(memAddr), .memWrData(memWrData),
    .memWe(memWe), .memRe(memRe), .memRdData(memRdData),
    .protectedOut(protectedOut)
  );

  task automatic apply(input logic ce, input logic we, input logic oe, input logic pf,
                       input logic [16:0] a, input logic [7:0] d,
                       input logic eWe, input logic eRe, input logic eProt, input string tag);
    obs_t e;
    @(negedge clk);
    hostCeN = ce; hostWeN = we; hostOeN = oe; pwrFail = pf;
    hostAddr = a; hostDataIn = d;
    e.we    = eWe;
    e.re    = eRe;
    e.oe    = eRe;
    e.prot  = eProt;
    e.dout  = eRe ? (a[7:0] ^ 8'h5A) : 8'h00;
    e.wdata = eWe ? d : 8'h00;
    e.addr  = (eWe || eRe) ? a : 17'h0;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // monitor: sample 1 ns before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (expQ.size() > 0) begin
        obs_t  e, got;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        got.we = memWe; got.re = memRe; got.oe = hostDataOe; got.prot = protectedOut;
        got.dout = hostDataOut; got.wdata = memWrData; got.addr = memAddr;
        checks++;
        if (got !== e) begin
          fails++;
          $display("FAIL %s: we/re/oe/prot=%b%b%b%b dout=%h wd=%h addr=%h expected %b%b%b%b dout=%h wd=%h addr=%h",
                   t, got.we, got.re, got.oe, got.prot, got.dout, got.wdata, got.addr,
                   e.we, e.re, e.oe, e.prot, e.dout, e.wdata, e.addr);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R12 reset state: normal service
    apply(1, 1, 1, 0, 17'h0, 8'h00, 0, 0, 0, "R12 reset");
    // R1 deselected, other strobes active
    apply(1, 0, 0, 0, 17'h1F0F0, 8'h3C, 0, 0, 0, "R1 deselect");
    // R2 output disable
    apply(0, 1, 1, 0, 17'h00777, 8'h11, 0, 0, 0, "R2 outdis");
    // R3 reads
    apply(0, 1, 0, 0, 17'h00123, 8'h00, 0, 1, 0, "R3 read a");
    apply(0, 1, 0, 0, 17'h1ABCD, 8'h00, 0, 1, 0, "R3 read b");
    // R4 writes, oe both levels
    apply(0, 0, 0, 0, 17'h00456, 8'hA7, 1, 0, 0, "R4 write oeLow");
    apply(0, 0, 1, 0, 17'h10001, 8'h5C, 1, 0, 0, "R4 write oeHigh");

    // R5 failure while idle
    apply(1, 1, 1, 1, 17'h0, 8'h00, 0, 0, 0, "R5 fail edge");
    apply(0, 0, 1, 1, 17'h00042, 8'hEE, 0, 0, 1, "R5 R8 write blocked");
    apply(0, 1, 0, 1, 17'h00043, 8'h00, 0, 0, 1, "R8 read blocked");
    apply(0, 1, 0, 0, 17'h00044, 8'h00, 0, 0, 1, "R8 last isolated cycle");
    // R10 recovery window
    for (int i = 0; i < CER; i++)
      apply(0, 0, 1, 0, 17'h00050, 8'h99, 0, 0, 1, "R10 recovering");
    apply(0, 0, 1, 0, 17'h00051, 8'h77, 1, 0, 0, "R10 resumed");

    // R11 refail during recovery
    apply(1, 1, 1, 1, 17'h0, 8'h00, 0, 0, 0, "R11 fail edge");
    apply(1, 1, 1, 0, 17'h0, 8'h00, 0, 0, 1, "R11 isolated");
    for (int i = 0; i < 5; i++)
      apply(0, 1, 0, 0, 17'h00060, 8'h00, 0, 0, 1, "R11 partial recovery");
    apply(0, 1, 0, 1, 17'h00061, 8'h00, 0, 0, 1, "R11 refail");
    apply(0, 1, 0, 0, 17'h00062, 8'h00, 0, 0, 1, "R11 isolated again");
    for (int i = 0; i < CER; i++)
      apply(0, 1, 0, 0, 17'h00063, 8'h00, 0, 0, 1, "R11 full window");
    apply(0, 1, 0, 0, 17'h00064, 8'h00, 0, 1, 0, "R11 resumed read");

    // R6 write in flight when power fails, ended by strobe release
    apply(0, 0, 1, 1, 17'h00100, 8'hC3, 1, 0, 0, "R6 fail during write");
    apply(0, 0, 1, 1, 17'h00100, 8'hC4, 1, 0, 1, "R6 write drains");
    apply(0, 1, 1, 1, 17'h00100, 8'h00, 0, 0, 1, "R6 strobe released");
    apply(0, 0, 1, 1, 17'h00101, 8'hC5, 0, 0, 1, "R6 R8 isolated after end");
    apply(1, 1, 1, 0, 17'h0, 8'h00, 0, 0, 1, "R10 isolated pf low");
    for (int i = 0; i < CER; i++)
      apply(1, 1, 1, 0, 17'h0, 8'h00, 0, 0, 1, "R10 recovering 2");

    // R7 read held past drain limit, R9 write inside draining read
    apply(0, 1, 0, 1, 17'h00200, 8'h00, 0, 1, 0, "R7 fail during read");
    apply(0, 1, 0, 1, 17'h00200, 8'h00, 0, 1, 1, "R7 drain 0");
    apply(0, 0, 0, 1, 17'h00201, 8'h81, 0, 0, 1, "R9 write in read drain");
    apply(0, 1, 0, 1, 17'h00202, 8'h00, 0, 1, 1, "R7 drain 2");
    apply(0, 1, 0, 1, 17'h00203, 8'h00, 0, 1, 1, "R7 drain 3");
    apply(0, 1, 0, 1, 17'h00204, 8'h00, 0, 0, 1, "R7 cut off");
    apply(1, 1, 1, 1, 17'h0, 8'h00, 0, 0, 1, "R12 status isolated");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule